// File: doc/BRIEF.md
# Software-Refilled Translation Cache with Entry Pinning

This block holds a small, fully associative set of virtual-page to physical-frame translations for 4 KiB pages. A lookup presents a virtual address and an access kind, and in the same cycle the block answers with one of three outcomes. A permitted hit returns the physical address, built from the cached frame number and the untouched 12-bit page offset. A hit whose access kind is not allowed raises a protection fault. An address with no cached translation raises a miss trap. The block never walks page tables on its own.

System software services the miss trap and writes the right translation through a fill stream. That stream is valid/ready: a beat transfers on a clock edge where both are high. The block lowers ready only in cycles where a flush or an unlock-all command is being applied, and the source must hold the beat until ready returns. A fill for a page that is already cached rewrites that entry. A fill for a new page takes a victim picked by a rotating pointer that passes over pinned (locked) entries. Pinned entries also stay valid across a context-switch flush. A separate command clears every pin at once.

Top module: `soft_tlb`

## Requirements
- R1: After reset no entry is valid and no entry is pinned, the replacement pointer is at entry 0, fill_ready is 1 and fill_err is 0.
- R2: A lookup with lk_valid high whose page number matches no valid entry sets lk_miss_trap in the same cycle, with lk_hit, lk_fault and lk_paddr all zero.
- R3: A lookup that matches a valid entry and is permitted sets lk_hit in the same cycle, and lk_paddr is the entry's frame number above the lookup's 12 low address bits.
- R4: Permission bits are bit 0 read, bit 1 write, bit 2 execute. lk_access is 0 for read, 1 for write, 2 for execute and 3 for a reserved kind that is never permitted. A matching lookup whose kind is not permitted sets lk_fault, with lk_hit 0 and lk_paddr 0.
- R5: A fill beat is taken on an edge where fill_valid and fill_ready are both 1. fill_ready is 0 in any cycle where cmd_flush or cmd_unlock is 1. A taken fill is visible to lookups from the next cycle on, and a lookup in the cycle of the fill still sees the old contents.
- R6: A taken fill whose page number is already cached rewrites that entry's frame, permissions and pin flag. It creates no second copy, leaves the pointer alone, and succeeds even when every entry is pinned.
- R7: A taken fill for a page that is not cached writes the first unpinned entry found from the pointer upward, wrapping at the top. The pointer then moves to the entry after the one written.
- R8: A pinned entry is never chosen as a victim. If every entry is pinned, a fill for an uncached page writes nothing and fill_err reads 1 from the next cycle. The next fill that writes an entry clears fill_err.
- R9: cmd_flush invalidates every unpinned entry in one cycle. Pinned entries stay valid with their contents.
- R10: cmd_unlock clears every pin flag in one cycle and leaves valid entries and their contents in place.
- R11: With lk_valid low, lk_hit, lk_miss_trap, lk_fault and lk_paddr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request present this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_access | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| lk_hit | output | 1 | Permitted translation found |
| lk_miss_trap | output | 1 | No cached translation; software refill needed |
| lk_fault | output | 1 | Translation found but access kind not permitted |
| lk_paddr | output | 32 | Physical address on a hit, zero otherwise |
| fill_valid | input | 1 | Fill beat offered |
| fill_ready | output | 1 | Fill beat can be taken this cycle |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pfn | input | 20 | Physical frame number to install |
| fill_perm | input | 3 | Permission bits: bit 0 read, bit 1 write, bit 2 execute |
| fill_lock | input | 1 | Pin the installed entry |
| fill_err | output | 1 | Last written-or-rejected fill was rejected, all entries pinned |
| cmd_flush | input | 1 | Invalidate all unpinned entries |
| cmd_unlock | input | 1 | Clear all pin flags |

## Verification
The two functions that can share a cycle are a lookup and a fill of the same page. The bench drives both in one cycle, checks that the lookup still reports the pre-fill state (a miss or the old frame), and checks on the next cycle that the new translation answers. A second collision is a fill offered in a flush or unlock cycle. There the bench checks that fill_ready is low, that the command takes effect, and that the offered page stays uncached. All outcomes are judged against a reference model in the bench that tracks entries, pins and the rotating pointer.

// File: rtl/stlb_pkg.sv
package stlb_pkg;

  localparam int PERM_W = 3;
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } access_t;

  // Reserved access kind is never allowed.
  function automatic logic perm_allows(input logic [PERM_W-1:0] perm, input access_t acc);
    case (acc)
      ACC_READ:  return perm[PERM_RD];
      ACC_WRITE: return perm[PERM_WR];
      ACC_EXEC:  return perm[PERM_EX];
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/stlb_cam.sv
module stlb_cam #(
  parameter int N     = 8,
  parameter int TAG_W = 20
) (
  input  logic [N-1:0]            ent_valid,
  input  logic [N-1:0][TAG_W-1:0] ent_tag,
  input  logic [TAG_W-1:0]        key,
  output logic [N-1:0]            match
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = ent_valid[g] && (ent_tag[g] == key);
  end

endmodule

// File: rtl/stlb_victim.sv
module stlb_victim #(
  parameter int N     = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     ent_lock,
  input  logic             advance,
  output logic [IDX_W-1:0] victim,
  output logic             found
);

  logic [IDX_W-1:0] rr_q;

  // Scan from the pointer upward; the closest unpinned slot wins.
  always_comb begin
    victim = rr_q;
    found  = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      int j;
      j = (int'(rr_q) + k) % N;
      if (!ent_lock[j]) begin
        victim = IDX_W'(j);
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (advance) begin
      rr_q <= (victim == IDX_W'(N - 1)) ? '0 : victim + IDX_W'(1);
    end
  end

endmodule

// File: rtl/stlb_store.sv
module stlb_store #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int PERM_W = 3,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [VPN_W-1:0]         wr_vpn,
  input  logic [PFN_W-1:0]         wr_pfn,
  input  logic [PERM_W-1:0]        wr_perm,
  input  logic                     wr_lock,
  input  logic                     flush,
  input  logic                     unlock_all,
  output logic [N-1:0]             ent_valid,
  output logic [N-1:0]             ent_lock,
  output logic [N-1:0][VPN_W-1:0]  ent_vpn,
  output logic [N-1:0][PFN_W-1:0]  ent_pfn,
  output logic [N-1:0][PERM_W-1:0] ent_perm
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid <= '0;
      ent_lock  <= '0;
      ent_vpn   <= '0;
      ent_pfn   <= '0;
      ent_perm  <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (flush) begin
          ent_valid[i] <= ent_valid[i] & ent_lock[i];
        end else if (wr_en && (wr_idx == IDX_W'(i))) begin
          ent_valid[i] <= 1'b1;
          ent_vpn[i]   <= wr_vpn;
          ent_pfn[i]   <= wr_pfn;
          ent_perm[i]  <= wr_perm;
        end
        if (unlock_all) begin
          ent_lock[i] <= 1'b0;
        end else if (!flush && wr_en && (wr_idx == IDX_W'(i))) begin
          ent_lock[i] <= wr_lock;
        end
      end
    end
  end

endmodule

// File: rtl/soft_tlb.sv
module soft_tlb #(
  parameter int N_ENTRIES = 8,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int OFF_W     = 12,
  localparam int VPN_W    = VA_W - OFF_W,
  localparam int PFN_W    = PA_W - OFF_W,
  localparam int PERM_W   = stlb_pkg::PERM_W,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [1:0]        lk_access,
  output logic              lk_hit,
  output logic              lk_miss_trap,
  output logic              lk_fault,
  output logic [PA_W-1:0]   lk_paddr,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              fill_lock,
  output logic              fill_err,
  input  logic              cmd_flush,
  input  logic              cmd_unlock
);

  logic [N_ENTRIES-1:0]             ent_valid;
  logic [N_ENTRIES-1:0]             ent_lock;
  logic [N_ENTRIES-1:0][VPN_W-1:0]  ent_vpn;
  logic [N_ENTRIES-1:0][PFN_W-1:0]  ent_pfn;
  logic [N_ENTRIES-1:0][PERM_W-1:0] ent_perm;

  logic [N_ENTRIES-1:0] lk_match;
  logic [N_ENTRIES-1:0] fill_match;

  // ---------------- lookup path ----------------
  stlb_cam #(.N(N_ENTRIES), .TAG_W(VPN_W)) u_lk_cam (
    .ent_valid (ent_valid),
    .ent_tag   (ent_vpn),
    .key       (lk_vaddr[VA_W-1:OFF_W]),
    .match     (lk_match)
  );

  logic              lk_any;
  logic [PFN_W-1:0]  lk_pfn;
  logic [PERM_W-1:0] lk_perm;
  logic              lk_ok;

  always_comb begin
    lk_pfn  = '0;
    lk_perm = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      lk_pfn  = lk_pfn  | ({PFN_W{lk_match[i]}}  & ent_pfn[i]);
      lk_perm = lk_perm | ({PERM_W{lk_match[i]}} & ent_perm[i]);
    end
  end

  assign lk_any = |lk_match;
  assign lk_ok  = stlb_pkg::perm_allows(lk_perm, stlb_pkg::access_t'(lk_access));

  assign lk_hit       = lk_valid &&  lk_any &&  lk_ok;
  assign lk_fault     = lk_valid &&  lk_any && !lk_ok;
  assign lk_miss_trap = lk_valid && !lk_any;
  assign lk_paddr     = lk_hit ? {lk_pfn, lk_vaddr[OFF_W-1:0]} : '0;

  // ---------------- fill path ----------------
  stlb_cam #(.N(N_ENTRIES), .TAG_W(VPN_W)) u_fill_cam (
    .ent_valid (ent_valid),
    .ent_tag   (ent_vpn),
    .key       (fill_vpn),
    .match     (fill_match)
  );

  logic             fill_fire;
  logic             fill_hit;
  logic [IDX_W-1:0] fill_hit_idx;
  logic             vic_found;
  logic [IDX_W-1:0] vic_idx;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             fill_err_q;

  always_comb begin
    fill_hit_idx = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (fill_match[i]) fill_hit_idx = IDX_W'(i);
    end
  end

  assign fill_ready = !(cmd_flush || cmd_unlock);
  assign fill_fire  = fill_valid && fill_ready;
  assign fill_hit   = |fill_match;
  assign wr_en      = fill_fire && (fill_hit || vic_found);
  assign wr_idx     = fill_hit ? fill_hit_idx : vic_idx;

  stlb_victim #(.N(N_ENTRIES)) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .ent_lock (ent_lock),
    .advance  (fill_fire && !fill_hit && vic_found),
    .victim   (vic_idx),
    .found    (vic_found)
  );

  stlb_store #(
    .N(N_ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .PERM_W(PERM_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_vpn     (fill_vpn),
    .wr_pfn     (fill_pfn),
    .wr_perm    (fill_perm),
    .wr_lock    (fill_lock),
    .flush      (cmd_flush),
    .unlock_all (cmd_unlock),
    .ent_valid  (ent_valid),
    .ent_lock   (ent_lock),
    .ent_vpn    (ent_vpn),
    .ent_pfn    (ent_pfn),
    .ent_perm   (ent_perm)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_err_q <= 1'b0;
    end else if (fill_fire) begin
      fill_err_q <= !(fill_hit || vic_found);
    end
  end

  assign fill_err = fill_err_q;

endmodule

// File: rtl/stlb_checker.sv
module stlb_checker #(
  parameter int N     = 8,
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [VA_W-1:0]  lk_vaddr,
  input logic             lk_hit,
  input logic             lk_miss_trap,
  input logic             lk_fault,
  input logic [PA_W-1:0]  lk_paddr,
  input logic             fill_err,
  input logic             cmd_flush,
  input logic             cmd_unlock,
  input logic [N-1:0]     ent_valid,
  input logic [N-1:0]     ent_lock,
  input logic [N-1:0]     lk_match,
  input logic             fill_fire,
  input logic             fill_hit,
  input logic             vic_found,
  input logic [IDX_W-1:0] vic_idx
);

  // R2, R3, R4: a live lookup gives exactly one outcome
  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot({lk_hit, lk_miss_trap, lk_fault}));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> ({lk_hit, lk_miss_trap, lk_fault} == 3'b000 && lk_paddr == '0));

  assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

  assert_no_duplicate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  assert_pinned_not_victim_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_fire && !fill_hit && vic_found) |-> !ent_lock[vic_idx]);

  assert_reject_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_fire && !fill_hit && !vic_found) |=> fill_err);

  assert_flush_keeps_pinned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_flush |=> (ent_valid == ($past(ent_valid) & $past(ent_lock))));

  assert_unlock_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_unlock |=> (ent_lock == '0 && ent_valid == $past(ent_valid)));

endmodule

bind soft_tlb stlb_checker #(
  .N(N_ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lk_valid     (lk_valid),
  .lk_vaddr     (lk_vaddr),
  .lk_hit       (lk_hit),
  .lk_miss_trap (lk_miss_trap),
  .lk_fault     (lk_fault),
  .lk_paddr     (lk_paddr),
  .fill_err     (fill_err),
  .cmd_flush    (cmd_flush),
  .cmd_unlock   (cmd_unlock),
  .ent_valid    (ent_valid),
  .ent_lock     (ent_lock),
  .lk_match     (lk_match),
  .fill_fire    (fill_fire),
  .fill_hit     (fill_hit),
  .vic_found    (vic_found),
  .vic_idx      (vic_idx)
);

// File: tb/sim_soft_tlb.sv
module sim_soft_tlb;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [1:0]  lk_access = '0;
  logic        lk_hit, lk_miss_trap, lk_fault;
  logic [31:0] lk_paddr;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic [2:0]  fill_perm = '0;
  logic        fill_lock = 1'b0;
  logic        fill_err;
  logic        cmd_flush = 1'b0;
  logic        cmd_unlock = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model
  bit          m_valid [N];
  bit          m_lock  [N];
  logic [19:0] m_vpn   [N];
  logic [19:0] m_pfn   [N];
  logic [2:0]  m_perm  [N];
  int          m_rr;
  bit          m_err;

  always #2.5 clk = ~clk;

  soft_tlb u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_access(lk_access),
    .lk_hit(lk_hit), .lk_miss_trap(lk_miss_trap), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_perm(fill_perm), .fill_lock(fill_lock), .fill_err(fill_err),
    .cmd_flush(cmd_flush), .cmd_unlock(cmd_unlock)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit allowed(input logic [2:0] perm, input logic [1:0] acc);
    case (acc)
      2'd0: return perm[0];
      2'd1: return perm[1];
      2'd2: return perm[2];
      default: return 1'b0;
    endcase
  endfunction

  // expected {hit, miss, fault, paddr}
  function automatic logic [34:0] expect_lk(input logic [19:0] vpn, input logic [11:0] off,
                                            input logic [1:0] acc);
    for (int i = 0; i < N; i++) begin
      if (m_valid[i] && m_vpn[i] == vpn) begin
        if (allowed(m_perm[i], acc)) return {3'b100, m_pfn[i], off};
        return {3'b001, 32'h0};
      end
    end
    return {3'b010, 32'h0};
  endfunction

  function automatic void model_fill(input logic [19:0] vpn, input logic [19:0] pfn,
                                     input logic [2:0] perm, input bit lk);
    int slot;
    slot = -1;
    for (int i = 0; i < N; i++) if (m_valid[i] && m_vpn[i] == vpn) slot = i;
    if (slot < 0) begin
      for (int k = 0; k < N; k++) begin
        if (slot < 0 && !m_lock[(m_rr + k) % N]) slot = (m_rr + k) % N;
      end
      if (slot >= 0) m_rr = (slot + 1) % N;
    end
    if (slot < 0) begin
      m_err = 1'b1;
    end else begin
      m_err = 1'b0;
      m_valid[slot] = 1'b1; m_vpn[slot] = vpn; m_pfn[slot] = pfn;
      m_perm[slot] = perm; m_lock[slot] = lk;
    end
  endfunction

  // All tasks start shortly after a rising edge and end 1 ns after the next one.
  task automatic probe(input string req, input logic [19:0] vpn, input logic [11:0] off,
                       input logic [1:0] acc);
    logic [34:0] e;
    lk_valid = 1'b1; lk_vaddr = {vpn, off}; lk_access = acc;
    #1;
    e = expect_lk(vpn, off, acc);
    check({req, " lookup"}, {lk_hit, lk_miss_trap, lk_fault, lk_paddr}, e);
  endtask

  task automatic lookup(input string req, input logic [19:0] vpn, input logic [11:0] off,
                        input logic [1:0] acc);
    probe(req, vpn, off, acc);
    @(posedge clk); #1;
    lk_valid = 1'b0;
  endtask

  task automatic fill(input string req, input logic [19:0] vpn, input logic [19:0] pfn,
                      input logic [2:0] perm, input bit lk, input bit same_cycle_probe);
    fill_valid = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_perm = perm; fill_lock = lk;
    if (same_cycle_probe) probe("R5 pre-fill view", vpn, 12'h5a5, 2'd0);
    else #1;
    check({req, " fill_ready"}, fill_ready, 1'b1);
    @(posedge clk); #1;
    fill_valid = 1'b0; lk_valid = 1'b0;
    model_fill(vpn, pfn, perm, lk);
    check({req, " fill_err"}, fill_err, m_err);
  endtask

  task automatic command(input string req, input bit fl, input bit ul, input bit offer);
    cmd_flush = fl; cmd_unlock = ul;
    fill_valid = offer; fill_vpn = 20'hbeef0; fill_pfn = 20'h1; fill_perm = 3'b111; fill_lock = 1'b0;
    #1;
    check({req, " R5 ready low"}, fill_ready, 1'b0);
    @(posedge clk); #1;
    cmd_flush = 1'b0; cmd_unlock = 1'b0; fill_valid = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (fl) m_valid[i] = m_valid[i] & m_lock[i];
      if (ul) m_lock[i] = 1'b0;
    end
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < N; i++) if (m_valid[i]) lookup(req, m_vpn[i], 12'h123, 2'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_lock[i] = 0; m_vpn[i] = '0; m_pfn[i] = '0; m_perm[i] = '0;
    end
    m_rr = 0; m_err = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: reset state
    check("R1 fill_ready", fill_ready, 1'b1);
    check("R1 fill_err", fill_err, 1'b0);
    // R11: idle lookup outputs quiet
    lk_vaddr = 32'h12345678; lk_access = 2'd0; #1;
    check("R11 idle outputs", {lk_hit, lk_miss_trap, lk_fault, lk_paddr}, 35'h0);
    @(posedge clk); #1;
    // R2: miss after reset
    lookup("R1 R2 miss", 20'h00010, 12'habc, 2'd0);

    // R5 + R3 + R4: fill read-only page while probing same page
    fill("R5", 20'h00010, 20'h7f001, 3'b001, 1'b0, 1'b1);
    lookup("R3 read hit", 20'h00010, 12'habc, 2'd0);
    lookup("R4 write fault", 20'h00010, 12'h001, 2'd1);
    lookup("R4 exec fault", 20'h00010, 12'h002, 2'd2);
    lookup("R4 reserved fault", 20'h00010, 12'h003, 2'd3);

    // R6: in-place rewrite, probed in the same cycle sees old frame
    fill("R6", 20'h00010, 20'h0aaaa, 3'b110, 1'b0, 1'b1);
    lookup("R6 new frame write", 20'h00010, 12'hfff, 2'd1);
    lookup("R6 read now denied", 20'h00010, 12'h000, 2'd0);

    // R7: fill to capacity and one more, eviction follows the pointer
    for (int i = 0; i < N + 2; i++) fill("R7", 20'h00100 + 20'(i), 20'h30000 + 20'(i), 3'b111, 1'b0, 1'b0);
    for (int i = 0; i < N + 2; i++) lookup("R7 eviction order", 20'h00100 + 20'(i), 12'h010, 2'd0);
    lookup("R7 oldest gone", 20'h00010, 12'h0, 2'd1);

    // R8: pin everything, then a new page is rejected
    command("R10", 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < N; i++) fill("R8", 20'h00200 + 20'(i), 20'h40000 + 20'(i), 3'b101, 1'b1, 1'b0);
    fill("R8 reject", 20'h00777, 20'h11111, 3'b111, 1'b0, 1'b0);
    check("R8 err set", fill_err, 1'b1);
    lookup("R8 rejected page absent", 20'h00777, 12'h0, 2'd0);
    sweep("R8 pinned kept");
    // R6: in-place works while all pinned, clears err
    fill("R6 pinned rewrite", 20'h00203, 20'h45555, 3'b111, 1'b1, 1'b0);
    check("R8 err cleared", fill_err, 1'b0);
    lookup("R6 pinned rewrite", 20'h00203, 12'h444, 2'd1);

    // R9: flush while a fill is offered; pinned entries survive
    command("R9", 1'b1, 1'b0, 1'b1);
    sweep("R9 pinned survive");
    lookup("R5 offered during flush not taken", 20'hbeef0, 12'h0, 2'd0);
    // R10: unlock keeps entries, next fill replaces again
    command("R10", 1'b0, 1'b1, 1'b1);
    sweep("R10 entries kept");
    fill("R10 replace after unlock", 20'h00888, 20'h12345, 3'b011, 1'b0, 1'b0);
    lookup("R10 replace after unlock", 20'h00888, 12'h777, 2'd1);
    command("R9 flush all", 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < N; i++) lookup("R9 all gone", 20'h00200 + 20'(i), 12'h0, 2'd0);

    // random phase
    for (int it = 0; it < 1500; it++) begin
      int op;
      logic [19:0] v;
      op = int'($urandom % 40);
      v = 20'h00c00 + 20'($urandom % 14);
      if (op < 14) fill("R7 R8 random", v, 20'($urandom), 3'($urandom), ($urandom % 7) == 0, ($urandom % 3) == 0);
      else if (op == 14) command("R9 random", 1'b1, 1'b0, ($urandom % 2) == 1);
      else if (op == 15) command("R10 random", 1'b0, 1'b1, ($urandom % 2) == 1);
      else lookup("R2 R3 R4 random", v, 12'($urandom), 2'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule